// File: doc/BRIEF.md
# Flash Program Command Sequencer

This block sits between a processor-style write bus and a small NOR-style storage array. It watches every bus write and decodes the command sequences that start a word program. It has two decoding modes. The normal mode needs a full unlock handshake before each program. The fast mode needs only a short two-write sequence for each word, and it stays in force until it is explicitly left. An accelerate input stands for the high-voltage level on the bank's protect/accelerate pin. While that input is high, the fast mode is forced.

A program operation takes a fixed number of clock cycles, set by a parameter. During that time the busy output is high and every bus write is dropped. When the operation finishes, the array word takes the bitwise AND of its old value and the new data, so a program can only clear bits. An active-low hardware reset stops a running program at once, leaves the target word unchanged and puts the decoder back in normal read mode. The array is not cleared by reset and starts fully erased (all ones).

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rstN` is low, `busy` and `bypassMode` read 0. After reset the decoder is in read mode, and an erased word reads all ones.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then (address, data) start a program. `busy` rises after the clock edge that takes the data write and stays high for exactly PGM_CYCLES cycles.
- R3: When a program completes, the word at the low MEM_AW address bits becomes old AND new. A program never turns a 0 bit into a 1.
- R4: In read mode, a wrong byte or a wrong address at any unlock step sends the decoder back to idle without programming anything. Writing F0h there has the same effect.
- R5: The writes AAh@555h, 55h@2AAh, 20h@555h enter the fast mode, and `bypassMode` goes high after the third write.
- R6: In the fast mode, A0h at any address followed by (address, data) programs one word. The pair can be repeated with no unlock writes, and the block stays in the fast mode afterwards.
- R7: In the fast mode, only A0h and 90h act as commands. Every other write (unlock bytes, F0h, 20h, a bare data write) is ignored.
- R8: In the fast mode, 90h followed by 00h (any addresses) returns to read mode. 90h followed by any other byte stays in the fast mode. Once back in read mode, A0h alone does not program.
- R9: Writes that arrive while `busy` is high change neither the decoder state nor the array.
- R10: Taking `rstN` low during a program drops `busy` at once. The target word is left unchanged and the decoder returns to read mode, including from the fast mode.
- R11: While `accel` is high and no program is running, the block enters the fast mode on the next clock with no writes needed. The 90h/00h exit does not take effect while `accel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Word address of the bus write |
| wrData | input | DATA_W | Data or command byte of the bus write |
| accel | input | 1 | Accelerate level, forces the fast mode |
| rdAddr | input | MEM_AW | Array read index |
| rdData | output | DATA_W | Array word at rdAddr (combinational) |
| busy | output | 1 | A program operation is in progress |
| bypassMode | output | 1 | Fast two-write program mode is active |

## Verification
The bound checker watches, on every cycle, the exact length of each busy interval, that a program only ever starts on a bus write, that a stored bit never rises at a held read index, that the fast mode is entered whenever the accelerate level is applied, that the fast mode is left only through a 00h write, and that outputs stay quiet during reset. Some behaviour only the bench scenarios can show: that malformed unlock sequences leave the array untouched, that commands arriving during a busy interval have no later effect, that a reset during a program leaves the word unchanged, and that the stored values equal the AND of every pattern written to each word.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNLK1,
    ST_UNLK2,
    ST_STD_PGM,
    ST_BYP,
    ST_BYP_PGM,
    ST_BYP_RST,
    ST_BUSY
  } seqState_t;

  typedef struct packed {
    logic startPgm;
  } ctlStrobes_t;

  localparam int unsigned ADDR_UNLK_A = 32'h555;
  localparam int unsigned ADDR_UNLK_B = 32'h2AA;

  localparam int unsigned CMD_UNLK_A  = 32'hAA;
  localparam int unsigned CMD_UNLK_B  = 32'h55;
  localparam int unsigned CMD_PROGRAM = 32'hA0;
  localparam int unsigned CMD_FASTON  = 32'h20;
  localparam int unsigned CMD_FASTX1  = 32'h90;
  localparam int unsigned CMD_FASTX2  = 32'h00;
  localparam int unsigned CMD_ABANDON = 32'hF0;

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accel,
  input  logic              pgmDone,
  output ctlStrobes_t       strobes,
  output logic              busy,
  output logic              bypassMode
);

  localparam logic [ADDR_W-1:0] A_UNLK_A = ADDR_W'(ADDR_UNLK_A);
  localparam logic [ADDR_W-1:0] A_UNLK_B = ADDR_W'(ADDR_UNLK_B);

  seqState_t state, stateNext;
  logic      retBypass, retBypassNext;

  logic isUnlkA, isUnlkB, isPgm, isFastOn, isFastX1, isFastX2;
  logic atA, atB;

  always_comb begin
    isUnlkA  = (wrData == DATA_W'(CMD_UNLK_A));
    isUnlkB  = (wrData == DATA_W'(CMD_UNLK_B));
    isPgm    = (wrData == DATA_W'(CMD_PROGRAM));
    isFastOn = (wrData == DATA_W'(CMD_FASTON));
    isFastX1 = (wrData == DATA_W'(CMD_FASTX1));
    isFastX2 = (wrData == DATA_W'(CMD_FASTX2));
    atA      = (wrAddr == A_UNLK_A);
    atB      = (wrAddr == A_UNLK_B);
  end

  always_comb begin
    stateNext        = state;
    retBypassNext    = retBypass;
    strobes.startPgm = 1'b0;
    case (state)
      ST_READ: begin
        if (accel)                      stateNext = ST_BYP;
        else if (wrEn && isUnlkA && atA) stateNext = ST_UNLK1;
      end
      ST_UNLK1: begin
        if (accel)                      stateNext = ST_BYP;
        else if (wrEn) begin
          if (isUnlkB && atB) stateNext = ST_UNLK2;
          else                stateNext = ST_READ;
        end
      end
      ST_UNLK2: begin
        if (accel)                      stateNext = ST_BYP;
        else if (wrEn) begin
          if (isPgm && atA)         stateNext = ST_STD_PGM;
          else if (isFastOn && atA) stateNext = ST_BYP;
          else                      stateNext = ST_READ;
        end
      end
      ST_STD_PGM: begin
        if (accel)                      stateNext = ST_BYP;
        else if (wrEn) begin
          strobes.startPgm = 1'b1;
          retBypassNext    = 1'b0;
          stateNext        = ST_BUSY;
        end
      end
      ST_BYP: begin
        if (wrEn) begin
          if (isPgm)         stateNext = ST_BYP_PGM;
          else if (isFastX1) stateNext = ST_BYP_RST;
        end
      end
      ST_BYP_PGM: begin
        if (wrEn) begin
          strobes.startPgm = 1'b1;
          retBypassNext    = 1'b1;
          stateNext        = ST_BUSY;
        end
      end
      ST_BYP_RST: begin
        if (wrEn) begin
          if (isFastX2 && !accel) stateNext = ST_READ;
          else                    stateNext = ST_BYP;
        end
      end
      ST_BUSY: begin
        if (pgmDone) stateNext = (retBypass || accel) ? ST_BYP : ST_READ;
      end
      default: stateNext = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READ;
      retBypass <= 1'b0;
    end else begin
      state     <= stateNext;
      retBypass <= retBypassNext;
    end
  end

  always_comb begin
    busy       = (state == ST_BUSY);
    bypassMode = (state == ST_BYP) || (state == ST_BYP_PGM) ||
                 (state == ST_BYP_RST) || ((state == ST_BUSY) && retBypass);
  end

endmodule

// File: rtl/fcs_dp.sv
module fcs_dp
  import fcs_pkg::*;
#(
  parameter int MEM_AW     = 4,
  parameter int DATA_W     = 8,
  parameter int PGM_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [MEM_AW-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MEM_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pgmDone
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam int CNT_W = $clog2(PGM_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [MEM_AW-1:0] latchIdx;
  logic [DATA_W-1:0] latchData;
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobes.startPgm) cnt <= CNT_W'(PGM_CYCLES);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.startPgm) begin
      latchIdx  <= wrIdx;
      latchData <= wrData;
    end
  end

  assign pgmDone = (cnt == CNT_W'(1));

  for (genvar g = 0; g < DEPTH; g++) begin : gWord
    initial words[g] = '1;
    always_ff @(posedge clk) begin
      if (pgmDone && (latchIdx == MEM_AW'(g)))
        words[g] <= words[g] & latchData;
    end
  end

  assign rdData = words[rdAddr];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int MEM_AW     = 4,
  parameter int PGM_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accel,
  input  logic [MEM_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              bypassMode
);

  ctlStrobes_t strobes;
  logic        pgmDone;

  fcs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .accel(accel), .pgmDone(pgmDone), .strobes(strobes),
    .busy(busy), .bypassMode(bypassMode)
  );

  fcs_dp #(.MEM_AW(MEM_AW), .DATA_W(DATA_W), .PGM_CYCLES(PGM_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrAddr[MEM_AW-1:0]),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pgmDone(pgmDone)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DATA_W     = 8,
  parameter int MEM_AW     = 4,
  parameter int PGM_CYCLES = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              accel,
  input logic [MEM_AW-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              busy,
  input logic              bypassMode
);

  localparam int RUN_W = $clog2(PGM_CYCLES + 1) + 1;

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  always @(posedge clk) begin
    if (!rstN) p_reset_quiet_r1: assert (!busy && !bypassMode);
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == RUN_W'(PGM_CYCLES));

  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < RUN_W'(PGM_CYCLES));

  p_start_on_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));

  p_no_bit_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdAddr) |-> ((~$past(rdData) & rdData) == '0));

  p_exit_by_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bypassMode) |-> $past(wrEn && wrData == '0 && !accel));

  p_busy_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(bypassMode));

  p_accel_entry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (accel && !busy) |=> bypassMode);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .DATA_W(DATA_W), .MEM_AW(MEM_AW), .PGM_CYCLES(PGM_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .accel(accel),
  .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .bypassMode(bypassMode)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 8;
  localparam int MEM_AW     = 4;
  localparam int PGM_CYCLES = 5;
  localparam int DEPTH      = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              accel = 1'b0;
  logic [MEM_AW-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              busy;
  logic              bypassMode;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] model [DEPTH];

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
                  .PGM_CYCLES(PGM_CYCLES)) u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .accel(accel), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .bypassMode(bypassMode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic rdChk(input int idx, input string tag);
    rdAddr = MEM_AW'(idx);
    #1;
    chk(int'(rdData), int'(model[idx]), tag);
  endtask

  task automatic stdProg(input int a, input logic [DATA_W-1:0] d, input string tag);
    int n;
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    wr(ADDR_W'(a), d);
    waitIdle(n);
    chk(n, PGM_CYCLES, tag);
    model[a % DEPTH] = model[a % DEPTH] & d;
  endtask

  task automatic bypProg(input int a, input logic [DATA_W-1:0] d, input string tag);
    int n;
    wr(ADDR_W'(a * 3), 8'hA0);
    wr(ADDR_W'(a), d);
    waitIdle(n);
    chk(n, PGM_CYCLES, tag);
    model[a % DEPTH] = model[a % DEPTH] & d;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) model[i] = '1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(busy, 0, "R1 busy in reset");
    chk(bypassMode, 0, "R1 mode in reset");
    rdChk(0, "R1 erased word");
    rstN = 1'b1;
    @(negedge clk);
    chk(bypassMode, 0, "R1 read mode after reset");

    // R2 and R3: standard program sweep over every word, twice
    for (int i = 0; i < DEPTH; i++) begin
      stdProg(i, 8'(i * 37 + 5), "R2 busy length");
      rdChk(i, "R3 first program");
    end
    for (int i = 0; i < DEPTH; i++) begin
      stdProg(i + DEPTH, 8'(8'hF0 ^ i), "R2 aliased address");
      rdChk(i, "R3 AND of two programs");
    end
    stdProg(0, 8'hFF, "R2 all ones");
    rdChk(0, "R3 cleared bits stay 0");

    // R4: broken unlock sequences
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'hA0); wr(12'h007, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R4 wrong address");
    rdChk(7, "R4 word untouched, wrong address");
    wr(12'h555, 8'hAA); wr(12'h555, 8'hF0); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    wr(12'h007, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R4 abandon byte");
    rdChk(7, "R4 word untouched, abandon");
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA1); wr(12'h007, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R4 wrong third byte");
    chk(bypassMode, 0, "R4 mode stays read");
    rdChk(7, "R4 word untouched, wrong byte");

    // R5: fast mode entry
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    chk(bypassMode, 0, "R5 not yet fast");
    wr(12'h555, 8'h20);
    chk(bypassMode, 1, "R5 fast mode entered");

    // R6: repeated two-write programs
    for (int k = 0; k < 8; k++) begin
      bypProg(9, 8'(~(1 << k) | (k * 16)), "R6 fast busy length");
      rdChk(9, "R6 fast program result");
      chk(bypassMode, 1, "R6 stays fast");
    end
    bypProg(10, 8'h5A, "R6 second word");
    rdChk(10, "R6 second word result");

    // R7: other commands ignored in fast mode
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h000, 8'hF0); wr(12'h555, 8'h20);
    wr(12'h003, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R7 no program without A0");
    chk(bypassMode, 1, "R7 still fast");
    rdChk(3, "R7 word untouched");
    bypProg(3, 8'h0F, "R7 program still works");
    rdChk(3, "R7 program result");

    // R8: fast mode exit
    wr(12'h000, 8'h90); wr(12'h000, 8'h12);
    chk(bypassMode, 1, "R8 bad second exit byte");
    wr(12'h000, 8'h90); wr(12'h123, 8'h00);
    chk(bypassMode, 0, "R8 exit to read");
    wr(12'h005, 8'hA0); wr(12'h005, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R8 bare A0 in read mode");
    rdChk(5, "R8 word untouched");

    // R9: writes during busy ignored
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h00B, 8'h3C);
    chk(busy, 1, "R9 program running");
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    waitIdle(n);
    model[11] = model[11] & 8'h3C;
    wr(12'h555, 8'hA0); wr(12'h00C, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R9 unlock during busy not kept");
    rdChk(11, "R9 running program completes");
    rdChk(12, "R9 word untouched");

    // R10: reset aborts a program
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h00D, 8'h00);
    @(negedge clk);
    chk(busy, 1, "R10 program running");
    rstN = 1'b0;
    #1;
    chk(busy, 0, "R10 busy drops at once");
    @(negedge clk);
    rstN = 1'b1;
    rdChk(13, "R10 aborted word unchanged");
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
    chk(bypassMode, 1, "R10 fast before reset");
    rstN = 1'b0;
    #1;
    chk(bypassMode, 0, "R10 reset leaves fast mode");
    @(negedge clk);
    rstN = 1'b1;

    // R11: accelerate input
    @(negedge clk);
    accel = 1'b1;
    @(negedge clk);
    chk(bypassMode, 1, "R11 accel entry");
    bypProg(14, 8'h55, "R11 accelerated busy length");
    rdChk(14, "R11 accelerated program");
    wr(12'h000, 8'h90); wr(12'h000, 8'h00);
    @(negedge clk);
    chk(bypassMode, 1, "R11 exit held off by accel");
    accel = 1'b0;
    wr(12'h000, 8'h90); wr(12'h000, 8'h00);
    chk(bypassMode, 0, "R11 exit after accel released");

    finishRun();
  end

endmodule